// File: doc/BRIEF.md
# PLL Divider Selection and Register Encoding

This block turns a reduced ratio of PLL output frequency to reference frequency, given as a numerator and a denominator, into the three register codes a PHY PLL expects. First it scales the ratio up. While the numerator is small and the denominator still has headroom, both are doubled together. Next it takes the trailing zero bits of the denominator, up to three of them, as a power-of-two post-divider. What remains of the denominator is the pre-divider.

The multiplier, pre-divider and post-divider are then range-checked. If they are legal, each is mapped to its code. These mappings are not linear. The multiplier code carries a prefix that depends on the multiplier's range. The two divider codes are bit windows taken from fixed patterns.

A caller pulses `start_i` with the ratio on the inputs and waits for the single-cycle `done_o`. Then it reads `err_o` and the three codes. The codes stay as they are until a later request completes without error.

Top module: `pll_div_encoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first completion, `done_o`, `err_o` and all three codes are zero.
- R2: A `start_i` accepted while idle with a zero numerator or zero denominator gives `done_o` and `err_o` high in the cycle right after the start edge. The codes are left unchanged.
- R3: For a nonzero ratio, the block doubles the numerator and the denominator together, one doubling per clock. It keeps doubling while the numerator is below 16 and the denominator is at most 128. After k doublings, `done_o` rises k+1 cycles after the cycle that follows the start edge.
- R4: The post-divider exponent e is the number of trailing zero bits of the normalised denominator, capped at 3. The post-divider is 2^e and the pre-divider is the denominator shifted right by e.
- R5: The legal ranges are multiplier 16..255, pre-divider 1..32 and post-divider 1..8. Any value outside these gives `err_o`=1 at `done_o` and leaves all three codes unchanged.
- R6: `mult_code_o` for multiplier m is 0xE0|(m-16) when m<32, 0xC0|(m-32) when m<64, 0x80|(m-64) when m<128, and m-128 otherwise.
- R7: `prediv_code_o` for pre-divider n is 0x1F when n=1. Otherwise it is bits [4:0] of 0xCB7A89C0 shifted right by n-1.
- R8: `postdiv_code_o` for post-divider o is bits [1:0] of 0x63 shifted right by 8-o. This gives 0, 1, 2 and 3 for o = 1, 2, 4 and 8.
- R9: `done_o` is high for exactly one cycle per accepted start. An accepted start clears `err_o`. The codes change only in a cycle where `done_o` is high.
- R10: `start_i` is ignored while a request is in progress, whatever the values on the ratio inputs. The result delivered is that of the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse, sampled while idle |
| ratio_num_i | input | NUM_W (8) | Ratio numerator |
| ratio_den_i | input | DEN_W (9) | Ratio denominator |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected (zero input or out of range) |
| mult_code_o | output | 8 | Encoded multiplier |
| prediv_code_o | output | 5 | Encoded pre-divider |
| postdiv_code_o | output | 2 | Encoded post-divider |

## Verification
On every cycle the assertions check the following:
- `done_o` never lasts more than one cycle.
- The codes move only with `done_o`, and never on an error completion.
- A zero operand is rejected on the very next cycle.
- An accepted nonzero request first clears `err_o`.

The scenarios in the bench cover what depends on arithmetic. These are the number of doubling cycles and the latency that follows from it, the trailing-zero split and its cap, the range limits, the exact code values from the three non-linear maps, and starts issued mid-request that have no effect on the result.

// File: rtl/pll_enc_pkg.sv
// Package: shared constants and the controller state type for the PLL
// divider encoder. Assumes an 8-bit multiplier code space.
package pll_enc_pkg;
    localparam int MULT_CODE_W    = 8;
    localparam int PREDIV_CODE_W  = 5;
    localparam int POSTDIV_CODE_W = 2;
    localparam int POST_EXP_W     = 2;
    localparam int POST_EXP_MAX   = 3;
    localparam int POSTDIV_W      = 4;

    localparam int NORM_NUM_LIMIT = 16;
    localparam int NORM_DEN_LIMIT = 128;

    localparam int MULT_MIN    = 16;
    localparam int MULT_MAX    = 255;
    localparam int PREDIV_MIN  = 1;
    localparam int PREDIV_MAX  = 32;
    localparam int POSTDIV_MIN = 1;
    localparam int POSTDIV_MAX = 8;

    localparam logic [31:0] PREDIV_PATTERN  = 32'hCB7A_89C0;
    localparam logic [7:0]  POSTDIV_PATTERN = 8'h63;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_NORM = 1'b1
    } enc_state_e;
endpackage

// File: rtl/pll_norm_step.sv
// Module: one normalisation step. It decides whether the ratio must be
// doubled again and gives the doubled pair. It assumes that the widths
// absorb the doubling (numerator < 16, denominator <= 128 before it).
module pll_norm_step
    import pll_enc_pkg::*;
#(
    parameter int NUM_W = 8,
    parameter int DEN_W = 9
) (
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             dbl_o,
    output logic [NUM_W-1:0] num_nxt_o,
    output logic [DEN_W-1:0] den_nxt_o
);
    localparam logic [NUM_W-1:0] NUM_LIM = NUM_W'(NORM_NUM_LIMIT);
    localparam logic [DEN_W-1:0] DEN_LIM = DEN_W'(NORM_DEN_LIMIT);

    // Purpose: doubling condition and the doubled operands
    always_comb begin
        dbl_o     = (num_i < NUM_LIM) && (den_i <= DEN_LIM);
        num_nxt_o = num_i << 1;
        den_nxt_o = den_i << 1;
    end
endmodule

// File: rtl/pll_div_split.sv
// Module: splits the denominator into a pre-divider and a power-of-two
// post-divider. The exponent counts trailing zeros, capped at
// POST_EXP_MAX. Assumes DEN_W > POST_EXP_MAX.
module pll_div_split
    import pll_enc_pkg::*;
#(
    parameter int DEN_W = 9
) (
    input  logic [DEN_W-1:0]      den_i,
    output logic [POST_EXP_W-1:0] exp_o,
    output logic [DEN_W-1:0]      prediv_o,
    output logic [POSTDIV_W-1:0]  postdiv_o
);
    logic stop;

    // Purpose: capped trailing-zero scan and the resulting divider pair
    always_comb begin
        exp_o = '0;
        stop  = 1'b0;
        for (int b = 0; b < POST_EXP_MAX; b++) begin
            if (!stop && !den_i[b]) begin
                exp_o = exp_o + POST_EXP_W'(1);
            end else begin
                stop = 1'b1;
            end
        end
        prediv_o  = den_i >> exp_o;
        postdiv_o = POSTDIV_W'(1) << exp_o;
    end
endmodule

// File: rtl/pll_code_enc.sv
// Module: maps the multiplier, pre-divider and post-divider exponent to
// their register codes. It is purely combinational. The inputs are
// assumed to be in range; the caller discards the codes otherwise.
module pll_code_enc
    import pll_enc_pkg::*;
#(
    parameter int NUM_W = 8,
    parameter int DEN_W = 9
) (
    input  logic [NUM_W-1:0]          mult_i,
    input  logic [DEN_W-1:0]          prediv_i,
    input  logic [POST_EXP_W-1:0]     exp_i,
    output logic [MULT_CODE_W-1:0]    mult_code_o,
    output logic [PREDIV_CODE_W-1:0]  prediv_code_o,
    output logic [POSTDIV_CODE_W-1:0] postdiv_code_o
);
    logic [MULT_CODE_W-1:0]   m8;
    logic [PREDIV_CODE_W-1:0] pre_sh;
    logic [POSTDIV_W-1:0]     post_o;
    logic [POSTDIV_W-1:0]     post_sh;

    // Purpose: multiplier code with a range-dependent prefix
    always_comb begin
        m8 = MULT_CODE_W'(mult_i);
        if (m8 < 8'd32) begin
            mult_code_o = 8'hE0 | (m8 - 8'd16);
        end else if (m8 < 8'd64) begin
            mult_code_o = 8'hC0 | (m8 - 8'd32);
        end else if (m8 < 8'd128) begin
            mult_code_o = 8'h80 | (m8 - 8'd64);
        end else begin
            mult_code_o = m8 - 8'd128;
        end
    end

    // Purpose: pre-divider code, a 5-bit window from a fixed pattern
    always_comb begin
        pre_sh = PREDIV_CODE_W'(prediv_i - DEN_W'(1));
        if (prediv_i == DEN_W'(1)) begin
            prediv_code_o = 5'h1F;
        end else begin
            prediv_code_o = PREDIV_CODE_W'(PREDIV_PATTERN >> pre_sh);
        end
    end

    // Purpose: post-divider code, a 2-bit window from a fixed pattern
    always_comb begin
        post_o         = POSTDIV_W'(1) << exp_i;
        post_sh        = POSTDIV_W'(8) - post_o;
        postdiv_code_o = POSTDIV_CODE_W'(POSTDIV_PATTERN >> post_sh);
    end
endmodule

// File: rtl/pll_div_encoder.sv
// Module: top of the PLL divider encoder. It accepts one request while
// idle, normalises it at one doubling per cycle, then in a single cycle
// splits, range-checks, encodes and pulses done. Synchronous active-low
// reset. Codes are updated only by a successful request.
module pll_div_encoder
    import pll_enc_pkg::*;
#(
    parameter int NUM_W = 8,
    parameter int DEN_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NUM_W-1:0]          ratio_num_i,
    input  logic [DEN_W-1:0]          ratio_den_i,
    output logic                      done_o,
    output logic                      err_o,
    output logic [MULT_CODE_W-1:0]    mult_code_o,
    output logic [PREDIV_CODE_W-1:0]  prediv_code_o,
    output logic [POSTDIV_CODE_W-1:0] postdiv_code_o
);
    enc_state_e                state_q;
    logic [NUM_W-1:0]          num_q;
    logic [DEN_W-1:0]          den_q;
    logic                      dbl;
    logic [NUM_W-1:0]          num_nxt;
    logic [DEN_W-1:0]          den_nxt;
    logic [POST_EXP_W-1:0]     post_exp;
    logic [DEN_W-1:0]          prediv;
    logic [POSTDIV_W-1:0]      postdiv;
    logic [MULT_CODE_W-1:0]    mult_code_c;
    logic [PREDIV_CODE_W-1:0]  prediv_code_c;
    logic [POSTDIV_CODE_W-1:0] postdiv_code_c;
    logic                      in_zero;
    logic                      range_ok;

    pll_norm_step #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_norm (
        .num_i     (num_q),
        .den_i     (den_q),
        .dbl_o     (dbl),
        .num_nxt_o (num_nxt),
        .den_nxt_o (den_nxt)
    );

    pll_div_split #(.DEN_W(DEN_W)) u_split (
        .den_i     (den_q),
        .exp_o     (post_exp),
        .prediv_o  (prediv),
        .postdiv_o (postdiv)
    );

    pll_code_enc #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_enc (
        .mult_i         (num_q),
        .prediv_i       (prediv),
        .exp_i          (post_exp),
        .mult_code_o    (mult_code_c),
        .prediv_code_o  (prediv_code_c),
        .postdiv_code_o (postdiv_code_c)
    );

    // Purpose: zero-operand detection and the legal-range check
    always_comb begin
        in_zero  = (ratio_num_i == '0) || (ratio_den_i == '0);
        range_ok = (32'(num_q) >= 32'(MULT_MIN)) && (32'(num_q) <= 32'(MULT_MAX))
                && (32'(prediv) >= 32'(PREDIV_MIN)) && (32'(prediv) <= 32'(PREDIV_MAX))
                && (32'(postdiv) >= 32'(POSTDIV_MIN)) && (32'(postdiv) <= 32'(POSTDIV_MAX));
    end

    // Purpose: request control, normalisation steps and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            num_q          <= '0;
            den_q          <= '0;
            done_o         <= 1'b0;
            err_o          <= 1'b0;
            mult_code_o    <= '0;
            prediv_code_o  <= '0;
            postdiv_code_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (in_zero) begin
                            err_o  <= 1'b1;
                            done_o <= 1'b1;
                        end else begin
                            err_o   <= 1'b0;
                            num_q   <= ratio_num_i;
                            den_q   <= ratio_den_i;
                            state_q <= ST_NORM;
                        end
                    end
                end
                ST_NORM: begin
                    if (dbl) begin
                        num_q <= num_nxt;
                        den_q <= den_nxt;
                    end else begin
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                        err_o   <= !range_ok;
                        if (range_ok) begin
                            mult_code_o    <= mult_code_c;
                            prediv_code_o  <= prediv_code_c;
                            postdiv_code_o <= postdiv_code_c;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_div_encoder_chk.sv
// Module: assertion checker for pll_div_encoder, bound to every instance.
module pll_div_encoder_chk
    import pll_enc_pkg::*;
#(
    parameter int NUM_W = 8,
    parameter int DEN_W = 9
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic [NUM_W-1:0]          num_i,
    input logic [DEN_W-1:0]          den_i,
    input enc_state_e                state,
    input logic                      done_o,
    input logic                      err_o,
    input logic [MULT_CODE_W-1:0]    mult_code_o,
    input logic [PREDIV_CODE_W-1:0]  prediv_code_o,
    input logic [POSTDIV_CODE_W-1:0] postdiv_code_o
);
    logic [MULT_CODE_W+PREDIV_CODE_W+POSTDIV_CODE_W-1:0] codes;
    assign codes = {mult_code_o, prediv_code_o, postdiv_code_o};

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(codes)); // R9

    AST_ERR_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> $stable(codes)); // R5

    AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && (num_i == '0 || den_i == '0))
        |=> (done_o && err_o)); // R2

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && num_i != '0 && den_i != '0)
        |=> (!done_o && !err_o)); // R9
endmodule

bind pll_div_encoder pll_div_encoder_chk #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .num_i          (ratio_num_i),
    .den_i          (ratio_den_i),
    .state          (state_q),
    .done_o         (done_o),
    .err_o          (err_o),
    .mult_code_o    (mult_code_o),
    .prediv_code_o  (prediv_code_o),
    .postdiv_code_o (postdiv_code_o)
);

// File: tb/sim_pll_div_encoder.sv
// Bench: behavioural reference model, compared against the outputs on
// every clock, sampled at the falling edge.
module sim_pll_div_encoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] num = '0;
    logic [8:0] den = '0;
    logic       done;
    logic       err;
    logic [7:0] mcode;
    logic [4:0] pcode;
    logic [1:0] ocode;

    int checks = 0;
    int errors = 0;
    int exp_err = 0;
    int exp_m = 0;
    int exp_p = 0;
    int exp_o = 0;

    pll_div_encoder u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .ratio_num_i    (num),
        .ratio_den_i    (den),
        .done_o         (done),
        .err_o          (err),
        .mult_code_o    (mcode),
        .prediv_code_o  (pcode),
        .postdiv_code_o (ocode)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int exp_done);
        checks++;
        if (int'(done) != exp_done || int'(err) != exp_err || int'(mcode) != exp_m
            || int'(pcode) != exp_p || int'(ocode) != exp_o) begin
            errors++;
            $display("FAIL %s: actual done=%0d err=%0d m=%h p=%h o=%0d expected done=%0d err=%0d m=%h p=%h o=%0d",
                     tag, done, err, mcode, pcode, ocode, exp_done, exp_err, exp_m, exp_p, exp_o);
        end
    endtask

    // One request; poke >= 0 issues a zero-valued start at that busy cycle.
    task automatic run(input string tag, input int n, input int d, input int poke);
        int m = n;
        int dd = d;
        int k = 0;
        int e = 0;
        int cn;
        int co;
        bit ok;
        while (m < 16 && dd <= 128) begin
            m = m * 2;
            dd = dd * 2;
            k++;
        end
        cn = dd;
        while (e < 3 && cn % 2 == 0) begin
            cn = cn / 2;
            e++;
        end
        co = 1 << e;
        ok = (m >= 16 && m <= 255 && cn >= 1 && cn <= 32);
        @(negedge clk);
        num = n[7:0];
        den = d[8:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0 || d == 0) begin
            exp_err = 1;
            check({tag, " R2 zero"}, 1);
            @(negedge clk);
            check({tag, " R9 after"}, 0);
            return;
        end
        exp_err = 0;
        for (int c = 0; c <= k; c++) begin
            check({tag, " R3 busy"}, 0);
            if (c == poke) begin
                num = 8'd0;
                den = 9'd0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (ok) begin
            exp_err = 0;
            if (m < 32) exp_m = 224 + m - 16;
            else if (m < 64) exp_m = 192 + m - 32;
            else if (m < 128) exp_m = 128 + m - 64;
            else exp_m = m - 128;
            exp_p = (cn == 1) ? 31 : int'((32'hCB7A89C0 >> (cn - 1)) & 32'h1F);
            exp_o = int'((8'h63 >> (8 - co)) & 8'h3);
        end else begin
            exp_err = 1;
        end
        check({tag, " done"}, 1);
        @(negedge clk);
        check({tag, " R9 pulse"}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 0);
        run("R2 zero num", 0, 5, -1);
        run("R3 R4 R6 R7 R8 1/1", 1, 1, -1);
        run("R6 R8 100/3", 100, 3, -1);
        run("R6 R4 40/12", 40, 12, -1);
        run("R6 R7 R8 255/256", 255, 256, -1);
        run("R3 R6 5/7", 5, 7, -1);
        run("R7 50/2", 50, 2, -1);
        run("R5 small mult 3/200", 3, 200, -1);
        run("R5 prediv 33 200/66", 200, 66, -1);
        run("R2 zero den", 7, 0, -1);
        run("R10 poke mid 1/3", 1, 3, 1);
        run("R10 poke last 3/5", 3, 5, 2);
        run("R8 R4 160/24", 160, 24, -1);
        run("R7 R6 70/31", 70, 31, -1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule